// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block turns single read and write requests from a synchronous host into bus cycles for an external asynchronous static RAM with 19 address bits and 8 data bits. It drives two chip selects of opposite polarity, an active-low output strobe, an active-low write strobe and a split data bus. The data bus is an output value, an output-enable and an input, which the pad ring joins into one tristate pin group. Every timing minimum of the memory is a nanosecond parameter. Each is turned into a clock count as ceiling(ns / clock period), and a per-phase down counter holds each bus phase for its count.

A request is taken only when the controller is idle. The address is put on the bus for one cycle while the device is deselected, and then the read or write phase runs. Read data is latched on the last clock of the access window. A one-cycle `done_o` pulse marks the end of each transfer. A standby input puts the device in its low-power retention state by driving the active-high select low. When standby is released, the controller waits one read-cycle time before it takes a new request.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `mem_cs_n_o`=1, `mem_cs_o`=1, `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0 and `done_o`=0.
- R2: An accepted read (`req_i`=1, `we_i`=0) presents the address for one deselected cycle. It then holds `mem_cs_n_o`=0 and `mem_oe_n_o`=0 with `mem_we_n_o`=1 for N_RD = ceil(max(tAA,tRC,tOE)/clock) cycles, which is 4 at the defaults. `rdata_o` takes the bus value sampled at the last of those edges. `done_o` is high in the cycle after that edge, N_RD+2 cycles after the request edge.
- R3: An accepted write holds `mem_we_n_o`=0 for exactly N_WR = ceil(max(tWP,tAW,tDW)/clock) cycles, which is 3 at the defaults. During that time `mem_dq_oe_o`=1 and `mem_dq_o`=`wdata_i`. The drive is released on the edge where `mem_we_n_o` rises, and `done_o` follows N_WR+2 cycles after the request edge.
- R4: `mem_addr_o` changes only on an edge where `mem_cs_n_o` is high both before and after that edge.
- R5: `mem_dq_oe_o` rises no sooner than N_OHZ = ceil(tOHZ/clock) cycles (2 at the defaults) after `mem_oe_n_o` last rose.
- R6: `mem_oe_n_o` or `mem_we_n_o` is low only while the device is selected (`mem_cs_n_o`=0 and `mem_cs_o`=1). `mem_oe_n_o` low implies `mem_we_n_o` high.
- R7: A request presented while a transfer is in progress is dropped. It causes no `done_o` and does not change memory contents.
- R8: `stby_i`=1 while idle takes priority over a request in the same cycle. It then holds `mem_cs_o`=0, `mem_cs_n_o`=1, both strobes high and the bus undriven, and requests are ignored for as long as standby lasts.
- R9: After `stby_i` falls, `mem_cs_o` returns high and the controller stays idle for N_REC = ceil(tRC/clock) cycles, 4 at the defaults. A request held from the release cycle pulls `mem_cs_n_o` low after exactly N_REC+3 clock edges.
- R10: `done_o` is a single-cycle pulse, and it is given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| stby_i | input | 1 | Standby/retention request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_cs_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output strobe |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_dq_o | output | DATA_W | Data bus value to drive |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus as seen from the pins |

## Verification
The memory model in the bench returns garbage until the output strobe has been low for the full access window. A controller that latches one edge early therefore reads back a wrong byte, and so does one with a short read phase. Requests are fired into the middle of a write and during standby. A controller that accepts them gives an extra completion pulse, and the overwritten byte shows up on read-back. The release from standby is timed edge by edge, so a short or missing recovery wait changes the measured count. Write pulse width, bus turnaround after a read and address movement are watched on every cycle, so a late drive release or an address change while the device is selected is reported.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RD, ST_TURN, ST_WR, ST_WREC, ST_SLEEP, ST_WAKE
  } seq_state_t;

  // Whole clock cycles covering a time in ns, never less than one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);
  // Address and write data change only at acceptance, while deselected
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (capture) rdata_o <= mem_dq_i;
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD   = 4,
  parameter int N_WR   = 3,
  parameter int N_WREC = 1,
  parameter int N_OHZ  = 2,
  parameter int N_REC  = 4,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             stby_i,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             done_o,
  output logic             cs_n_o,
  output logic             cs_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o
);
  seq_state_t state_q, state_d;
  logic       op_we_q;
  logic       finish;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (stby_i) state_d = ST_SLEEP;
        else if (req_i) begin
          state_d = ST_ADDR;
          accept  = 1'b1;
        end
      end
      ST_ADDR:  state_d = op_we_q ? ST_WR : ST_RD;
      ST_RD:    if (expired) state_d = ST_TURN;
      ST_TURN:  if (expired) state_d = ST_IDLE;
      ST_WR:    if (expired) state_d = ST_WREC;
      ST_WREC:  if (expired) state_d = ST_IDLE;
      ST_SLEEP: if (!stby_i) state_d = ST_WAKE;
      ST_WAKE:  if (expired) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign capture = (state_q == ST_RD) && expired;
  assign finish  = capture || ((state_q == ST_WR) && expired);
  assign load    = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_RD:   load_val = CNT_W'(N_RD - 1);
      ST_TURN: load_val = CNT_W'(N_OHZ - 1);
      ST_WR:   load_val = CNT_W'(N_WR - 1);
      ST_WREC: load_val = CNT_W'(N_WREC - 1);
      ST_WAKE: load_val = CNT_W'(N_REC - 1);
      default: load_val = '0;
    endcase
  end

  // State and all pin strobes registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_we_q <= 1'b0;
      done_o  <= 1'b0;
      cs_n_o  <= 1'b1;
      cs_o    <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_we_q <= we_i;
      done_o  <= finish;
      cs_n_o  <= !((state_d == ST_RD) || (state_d == ST_WR));
      cs_o    <= (state_d != ST_SLEEP);
      oe_n_o  <= (state_d != ST_RD);
      we_n_o  <= (state_d != ST_WR);
      dq_oe_o <= (state_d == ST_WR);
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_AW_NS   = 55,
  parameter int T_DW_NS   = 30,
  parameter int T_OHZ_NS  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stby_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int N_RD   = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)),
                               ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int N_WR   = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                               ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int N_WREC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - N_WR - 1);
  localparam int N_OHZ  = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int N_REC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int N_MAX  = imax(imax(imax(N_RD, N_WR), imax(N_WREC, N_OHZ)), N_REC);
  localparam int CNT_W  = $clog2(N_MAX + 1);

  logic             load, expired, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  sram_seq_fsm #(
    .N_RD(N_RD), .N_WR(N_WR), .N_WREC(N_WREC), .N_OHZ(N_OHZ),
    .N_REC(N_REC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .stby_i(stby_i),
    .expired(expired), .load(load), .load_val(load_val), .accept(accept),
    .capture(capture), .done_o(done_o), .cs_n_o(mem_cs_n_o), .cs_o(mem_cs_o),
    .oe_n_o(mem_oe_n_o), .we_n_o(mem_we_n_o), .dq_oe_o(mem_dq_oe_o)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .addr_i(addr_i), .wdata_i(wdata_i), .mem_dq_i(mem_dq_i),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int CLK_NS   = 20,
  parameter int T_RC_NS  = 70,
  parameter int T_WP_NS  = 50,
  parameter int T_AW_NS  = 55,
  parameter int T_DW_NS  = 30,
  parameter int T_OHZ_NS = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_cs_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o
);
  localparam int C_WR  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                              ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int C_OHZ = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int C_REC = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int SAT   = 1000;

  int wlow_q, oehi_q, wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wlow_q <= 0;
      oehi_q <= SAT;
      wake_q <= SAT;
    end else begin
      wlow_q <= !mem_we_n_o ? ((wlow_q < SAT) ? wlow_q + 1 : SAT) : 0;
      oehi_q <= !mem_oe_n_o ? 0 : ((oehi_q < SAT) ? oehi_q + 1 : SAT);
      wake_q <= !mem_cs_o   ? 0 : ((wake_q < SAT) ? wake_q + 1 : SAT);
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (mem_cs_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && !done_o));

  p_read_we_high_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n_o |-> mem_we_n_o);

  p_drive_only_in_write_r3: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe_o |-> !mem_we_n_o);

  p_release_with_we_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n_o) |-> !mem_dq_oe_o);

  p_write_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n_o) |-> (wlow_q == C_WR));

  p_addr_deselected_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr_o) |-> (mem_cs_n_o && $past(mem_cs_n_o)));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe_o) |-> (oehi_q >= C_OHZ));

  p_strobe_selected_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n_o || !mem_we_n_o) |-> (!mem_cs_n_o && mem_cs_o));

  p_retention_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_o |-> (mem_cs_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  p_recovery_r9: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n_o |-> (wake_q >= C_REC));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_WP_NS(T_WP_NS),
  .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS), .T_OHZ_NS(T_OHZ_NS)
) u_chk (
  .clk(clk), .rst(rst), .done_o(done_o), .mem_addr_o(mem_addr_o),
  .mem_cs_n_o(mem_cs_n_o), .mem_cs_o(mem_cs_o), .mem_oe_n_o(mem_oe_n_o),
  .mem_we_n_o(mem_we_n_o), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int PER = 20;
  // Cycle counts from the requirements at the default timing
  localparam int E_RD  = (70 + PER - 1) / PER;   // 4
  localparam int E_WR  = (55 + PER - 1) / PER;   // 3
  localparam int E_OHZ = (25 + PER - 1) / PER;   // 2
  localparam int E_REC = (70 + PER - 1) / PER;   // 4

  logic clk = 1'b0, rst = 1'b1;
  logic req_i = 1'b0, we_i = 1'b0, stby_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic done_o, mem_cs_n_o, mem_cs_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o;
  logic [DW-1:0] rdata_o, mem_dq_o;
  logic [DW-1:0] mem_dq_i = 8'hEE;
  logic [AW-1:0] mem_addr_o;

  sram_cycle_ctrl uut (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .stby_i(stby_i), .done_o(done_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o), .mem_cs_o(mem_cs_o),
    .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
  );

  always #10 clk = ~clk;

  typedef struct { bit rd; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t exp_q[$];
  logic [DW-1:0] model_mem[int];
  logic [DW-1:0] ref_mem[int];
  int checks = 0, errors = 0, dones = 0, pushed = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Memory model and bus monitors, all on the falling edge
  int oe_cnt = 0, wlow = 0, oehi = 100;
  logic [AW-1:0] last_addr = '0;
  logic last_cs_n = 1'b1, last_dq_oe = 1'b0, last_oe_n = 1'b1, last_we_n = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n_o && mem_cs_o && !mem_we_n_o && mem_dq_oe_o)
        model_mem[int'(mem_addr_o)] = mem_dq_o;
      if (!mem_cs_n_o && mem_cs_o && !mem_oe_n_o && mem_we_n_o) oe_cnt++;
      else oe_cnt = 0;
      if (oe_cnt >= E_RD)
        mem_dq_i <= model_mem.exists(int'(mem_addr_o)) ? model_mem[int'(mem_addr_o)] : 8'h00;
      else
        mem_dq_i <= 8'hEE;
      if (mem_addr_o != last_addr)
        check(mem_cs_n_o && last_cs_n, "R4", "address moved while selected", 0, 1);
      if (!mem_we_n_o) wlow++;
      else if (wlow != 0) begin
        check(wlow == E_WR, "R3", "write strobe width", wlow, E_WR);
        wlow = 0;
      end
      if (mem_dq_oe_o && !last_dq_oe)
        check(oehi >= E_OHZ, "R5", "drive after output strobe", oehi, E_OHZ);
      if (!mem_oe_n_o) oehi = 0; else if (oehi < 100) oehi++;
      if ((!mem_oe_n_o && last_oe_n) || (!mem_we_n_o && last_we_n))
        check(!mem_cs_n_o && mem_cs_o && (mem_oe_n_o || mem_we_n_o), "R6",
              "strobe without select", {mem_cs_n_o, mem_cs_o}, 2'b01);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (it.rd) check(rdata_o == it.d, "R2", "read data", rdata_o, it.d);
        end
      end
      last_addr = mem_addr_o; last_cs_n = mem_cs_n_o; last_dq_oe = mem_dq_oe_o;
      last_oe_n = mem_oe_n_o; last_we_n = mem_we_n_o;
    end
  end

  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    int lat;
    it.rd = !w; it.a = a;
    it.d = w ? d : (ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    if (w) ref_mem[int'(a)] = d;
    exp_q.push_back(it); pushed++;
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk); req_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 50) begin @(negedge clk); lat++; end
    if (w) check(lat == E_WR + 2, "R3", "write latency", lat, E_WR + 2);
    else   check(lat == E_RD + 2, "R2", "read latency", lat, E_RD + 2);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    item_t it;
    repeat (4) @(negedge clk);
    check(mem_cs_n_o && mem_cs_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o && !done_o,
          "R1", "reset pins", {mem_cs_n_o, mem_cs_o, mem_oe_n_o, mem_we_n_o, mem_dq_oe_o}, 5'b11110);
    rst = 1'b0;
    @(negedge clk);

    do_op(1, 19'h00000, 8'h5A);
    do_op(1, 19'h7FFFF, 8'hA5);
    do_op(1, 19'h2A5A5, 8'hFF);
    do_op(1, 19'h13579, 8'h00);
    do_op(0, 19'h00000, 8'h00);
    do_op(0, 19'h7FFFF, 8'h00);
    do_op(0, 19'h2A5A5, 8'h00);
    do_op(0, 19'h13579, 8'h00);
    do_op(1, 19'h2A5A5, 8'h3C);
    do_op(0, 19'h2A5A5, 8'h00);

    // R7: second request in the middle of a write is dropped
    it.rd = 0; it.a = 19'h00100; it.d = 8'h11;
    ref_mem[int'(19'h00100)] = 8'h11;
    exp_q.push_back(it); pushed++;
    req_i = 1'b1; we_i = 1'b1; addr_i = 19'h00100; wdata_i = 8'h11;
    @(negedge clk); req_i = 1'b0;
    @(negedge clk); @(negedge clk);
    req_i = 1'b1; wdata_i = 8'h99;
    @(negedge clk); req_i = 1'b0;
    repeat (10) @(negedge clk);
    do_op(0, 19'h00100, 8'h00);

    // R8: standby wins over a same-cycle request, requests ignored while asleep
    stby_i = 1'b1; req_i = 1'b1; we_i = 1'b1; addr_i = 19'h00000; wdata_i = 8'hEE;
    @(negedge clk); req_i = 1'b0;
    check(!mem_cs_o && mem_cs_n_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o, "R8",
          "retention pins", {mem_cs_o, mem_cs_n_o, mem_dq_oe_o}, 3'b010);
    repeat (3) @(negedge clk);
    req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    repeat (5) @(negedge clk);
    check(!mem_cs_o && done_o == 1'b0, "R8", "held in retention", mem_cs_o, 0);

    // R9: recovery time, request held from release
    it.rd = 1; it.a = 19'h00000; it.d = 8'h5A;
    exp_q.push_back(it); pushed++;
    stby_i = 1'b0; req_i = 1'b1; we_i = 1'b0; addr_i = 19'h00000;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); n++;
      if (!mem_cs_n_o) break;
    end
    req_i = 1'b0;
    check(n == E_REC + 3, "R9", "edges to first select after standby", n, E_REC + 3);
    repeat (12) @(negedge clk);

    check(dones == pushed && exp_q.size() == 0, "R10", "done count", dones, pushed);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule